// File: doc/BRIEF.md
# Data-Link Bit Destuffer and Byte Matcher

This block sits behind a T1 framer that has already pulled the data-link bits out of the superframe. It takes one serial bit per strobe and can discard the zeros that a transmitter inserted after runs of ones. It packs the remaining bits into bytes, filling the byte from bit 0 upward, and loads each finished byte into a receive register that the host can read.

Each finished byte is compared with two host-written pattern bytes. If the byte equals either pattern, a sticky status flag is set. An active-low interrupt follows that flag when the host has enabled it. A second status flag reports that a new byte is ready. A small register port gives the host access to the receive byte, both patterns, the status and the control bits.

Top module: `fdl_rx_deser`

## Requirements
- R1: With destuffing enabled (control bit 0 = 1), a zero that arrives right after exactly five consecutive ones is discarded. Ones are never discarded.
- R2: With destuffing enabled, a zero that arrives after six or more consecutive ones is kept as data.
- R3: With destuffing disabled (control bit 0 = 0), every strobed bit is kept unchanged.
- R4: Kept bits fill the byte from bit 0 upward: the first kept bit becomes bit 0 of the byte.
- R5: A finished byte that equals pattern A (address 1) or pattern B (address 2) sets status bit 0. The bit stays set until the status register is read.
- R6: `irq_n` is low exactly when status bit 0 is set and the interrupt mask (control bit 1) is 1. Otherwise `irq_n` is high.
- R7: The count of consecutive ones returns to zero on any strobed zero. It saturates instead of wrapping, so a run of thirteen ones followed by a zero keeps the zero.
- R8: A discarded bit does not count toward the byte. A byte finishes only after eight kept bits. A finished byte sets status bit 1.
- R9: The receive register (address 0) takes the whole new byte in the cycle after its eighth kept bit and holds its value at all other times.
- R10: A read strobe at the status address (3) clears status bits 0 and 1. Bits presented while `bit_valid` is low have no effect.
- R11: Register map: 0 receive byte (read-only), 1 pattern A, 2 pattern B, 3 status (read-only), 4 control. Unused addresses read zero. After reset every register is zero and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Serial data-link bit |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| reg_addr | input | 3 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe; a read at the status address clears it |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr`, combinational |
| irq_n | output | 1 | Active-low match interrupt |

## Verification
The assertions check the following on every cycle:
- the ones count never exceeds its saturation value and returns to zero after a strobed zero;
- ones are never dropped;
- the bit index does not move while no bit is kept;
- status bit 1 follows every finished byte;
- the match flag holds until it is read;
- the receive register holds between bytes;
- `irq_n` stays high while the mask is off.

Only the bench scenarios can show the following:
- the exact-five rule against the six-ones case;
- the effect of saturation on long runs;
- bit order within the byte;
- correct matching and pattern recovery for every byte value, with and without stuffing.

// File: rtl/fdl_rx_pkg.sv
package fdl_rx_pkg;
    typedef enum logic [2:0] {
        ADDR_RXBYTE = 3'd0,
        ADDR_PAT_A  = 3'd1,
        ADDR_PAT_B  = 3'd2,
        ADDR_STATUS = 3'd3,
        ADDR_CTRL   = 3'd4
    } reg_addr_e;

    localparam int STAT_MATCH_BIT   = 0;
    localparam int STAT_READY_BIT   = 1;
    localparam int CTRL_DESTUFF_BIT = 0;
    localparam int CTRL_MASK_BIT    = 1;
endpackage

// File: rtl/fdl_destuff.sv
module fdl_destuff #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bit_i,
    input  logic valid_i,
    output logic keep_o,
    output logic bit_o
);
    localparam int CNT_W = $clog2(RUN_LEN + 2);
    localparam logic [CNT_W-1:0] CNT_RUN = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(RUN_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] ones;
    } state_t;

    state_t q, d;
    logic   drop;

    always_comb begin
        d    = q;
        drop = 1'b0;
        if (valid_i) begin
            if (bit_i) begin
                if (q.ones != CNT_SAT) begin
                    d.ones = q.ones + 1'b1;
                end
            end else begin
                drop   = en_i && (q.ones == CNT_RUN);
                d.ones = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign keep_o = valid_i && !drop;
    assign bit_o  = bit_i;

    // R7: the run count saturates and never passes the limit
    p_ones_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.ones <= CNT_SAT);

    // R7: a strobed zero returns the run count to zero
    p_zero_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !bit_i) |=> (q.ones == '0));

    // R1: a strobed one is always kept
    p_ones_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && bit_i) |-> keep_o);
endmodule

// File: rtl/fdl_shift.sv
module fdl_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep_i,
    input  logic              bit_i,
    output logic              done_o,
    output logic [DATA_W-1:0] byte_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
    } state_t;

    state_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        if (keep_i) begin
            d.sh = {bit_i, q.sh[DATA_W-1:1]};
            if (q.idx == IDX_LAST) begin
                done_o = 1'b1;
                d.idx  = '0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    assign byte_o = {bit_i, q.sh[DATA_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R8: the bit index only moves on a kept bit
    p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !keep_i |=> $stable(q.idx));

    // R8: a finished byte restarts the bit index
    p_idx_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (q.idx == '0));
endmodule

// File: rtl/fdl_match.sv
module fdl_match #(
    parameter int DATA_W = 8,
    parameter int NPAT   = 2
) (
    input  logic                        strobe_i,
    input  logic [DATA_W-1:0]           byte_i,
    input  logic [NPAT-1:0][DATA_W-1:0] pat_i,
    output logic                        hit_o
);
    logic [NPAT-1:0] eq;

    for (genvar g = 0; g < NPAT; g++) begin : g_cmp
        assign eq[g] = (byte_i == pat_i[g]);
    end

    assign hit_o = strobe_i && (|eq);
endmodule

// File: rtl/fdl_rx_deser.sv
module fdl_rx_deser
    import fdl_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RUN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_valid,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    localparam int NPAT = 2;

    typedef struct packed {
        logic [DATA_W-1:0]           rx_byte;
        logic [NPAT-1:0][DATA_W-1:0] pat;
        logic                        match;
        logic                        ready;
        logic                        destuff_en;
        logic                        irq_mask;
    } state_t;

    state_t            q, d;
    logic              keep;
    logic              kbit;
    logic              byte_done;
    logic [DATA_W-1:0] new_byte;
    logic              hit;
    logic              stat_rd;

    fdl_destuff #(.RUN_LEN(RUN_LEN)) i_destuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (q.destuff_en),
        .bit_i   (bit_in),
        .valid_i (bit_valid),
        .keep_o  (keep),
        .bit_o   (kbit)
    );

    fdl_shift #(.DATA_W(DATA_W)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .keep_i (keep),
        .bit_i  (kbit),
        .done_o (byte_done),
        .byte_o (new_byte)
    );

    fdl_match #(.DATA_W(DATA_W), .NPAT(NPAT)) i_match (
        .strobe_i (byte_done),
        .byte_i   (new_byte),
        .pat_i    (q.pat),
        .hit_o    (hit)
    );

    assign stat_rd = reg_rd && (reg_addr == ADDR_STATUS);

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_PAT_A: d.pat[0] = reg_wdata;
                ADDR_PAT_B: d.pat[1] = reg_wdata;
                ADDR_CTRL: begin
                    d.destuff_en = reg_wdata[CTRL_DESTUFF_BIT];
                    d.irq_mask   = reg_wdata[CTRL_MASK_BIT];
                end
                default: ;
            endcase
        end
        if (stat_rd) begin
            d.match = 1'b0;
            d.ready = 1'b0;
        end
        if (byte_done) begin
            d.rx_byte = new_byte;
            d.ready   = 1'b1;
        end
        if (hit) begin
            d.match = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_RXBYTE: reg_rdata = q.rx_byte;
            ADDR_PAT_A:  reg_rdata = q.pat[0];
            ADDR_PAT_B:  reg_rdata = q.pat[1];
            ADDR_STATUS: begin
                reg_rdata[STAT_MATCH_BIT] = q.match;
                reg_rdata[STAT_READY_BIT] = q.ready;
            end
            ADDR_CTRL: begin
                reg_rdata[CTRL_DESTUFF_BIT] = q.destuff_en;
                reg_rdata[CTRL_MASK_BIT]    = q.irq_mask;
            end
            default: ;
        endcase
    end

    assign irq_n = !(q.match && q.irq_mask);

    // R8: every finished byte raises the ready flag
    p_ready_after_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> q.ready);

    // R5: the match flag stays set until the status register is read
    p_match_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.match && !stat_rd) |=> q.match);

    // R9: the receive register holds between finished bytes
    p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done |=> $stable(q.rx_byte));

    // R6: with the mask off the interrupt stays inactive
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !q.irq_mask |-> irq_n);
endmodule

// File: tb/test_fdl_rx_deser.sv
module test_fdl_rx_deser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    int ones_tx = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    fdl_rx_deser i_fdl_rx_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ones_tx = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b; bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0; bit_in = ~b;
    endtask

    task automatic send_stuffed(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (v[i]) ones_tx++; else ones_tx = 0;
            if (ones_tx == 5) begin
                send_bit(1'b0);
                ones_tx = 0;
            end
        end
    endtask

    task automatic send_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic exp_m;
        do_reset();
        // R11 reset state
        peek(3'd0, rv); check("R11 rx reset", rv, 8'h00);
        peek(3'd3, rv); check("R11 status reset", rv, 8'h00);
        peek(3'd4, rv); check("R11 ctrl reset", rv, 8'h00);
        peek(3'd1, rv); check("R11 patA reset", rv, 8'h00);
        check("R11 irq reset", irq_n, 1);

        // Phase 1: stuffed sweep, destuff on, mask on
        wr(3'd1, 8'h7E); wr(3'd2, 8'h3C); wr(3'd4, 8'h03);
        peek(3'd4, rv); check("R11 ctrl readback", rv, 8'h03);
        peek(3'd2, rv); check("R11 patB readback", rv, 8'h3C);
        peek(3'd5, rv); check("R11 unused addr", rv, 8'h00);
        for (int v = 0; v < 256; v++) begin
            send_stuffed(8'(v));
            exp_m = (v == 8'h7E) || (v == 8'h3C);
            peek(3'd0, rv); check("R1 R4 stuffed byte", rv, v);
            check("R6 irq with mask", irq_n, !exp_m);
            rd(3'd3, rv); check("R5 R8 status", rv, {6'd0, 1'b1, exp_m});
            peek(3'd3, rv); check("R10 status cleared", rv, 8'h00);
        end

        // Phase 2: raw sweep, destuff off, mask off
        do_reset();
        wr(3'd1, 8'hA5); wr(3'd2, 8'h5A); wr(3'd4, 8'h00);
        for (int v = 0; v < 256; v++) begin
            send_raw(8'(v));
            exp_m = (v == 8'hA5) || (v == 8'h5A);
            peek(3'd0, rv); check("R3 raw byte", rv, v);
            check("R6 irq masked", irq_n, 1);
            rd(3'd3, rv); check("R5 raw status", rv, {6'd0, 1'b1, exp_m});
        end

        // R6: sticky match seen once mask turns on, cleared by read
        send_raw(8'hA5);
        check("R6 irq masked off", irq_n, 1);
        wr(3'd4, 8'h02);
        check("R6 irq after unmask", irq_n, 0);
        rd(3'd3, rv); check("R5 status before clear", rv, 8'h03);
        check("R6 irq after clear", irq_n, 1);

        // R2: six ones then zero, zero kept
        do_reset();
        wr(3'd4, 8'h01);
        send_ones(6); send_bit(1'b0); send_bit(1'b1);
        peek(3'd0, rv); check("R2 six ones keep zero", rv, 8'hBF);

        // R1 R8 R9: five ones, zero dropped, byte needs eight kept bits
        do_reset();
        wr(3'd4, 8'h01);
        send_ones(5); send_bit(1'b0); send_ones(2);
        peek(3'd3, rv); check("R8 not ready after 7 kept", rv, 8'h00);
        peek(3'd0, rv); check("R9 rx holds mid byte", rv, 8'h00);
        send_bit(1'b1);
        peek(3'd0, rv); check("R1 drop after five", rv, 8'hFF);
        peek(3'd3, rv); check("R8 ready after 8 kept", rv, 8'h02);

        // R7: thirteen ones then zero, saturated count keeps the zero
        do_reset();
        wr(3'd4, 8'h01);
        send_ones(8);
        peek(3'd0, rv); check("R7 first byte", rv, 8'hFF);
        send_ones(5);
        peek(3'd0, rv); check("R9 rx holds partial", rv, 8'hFF);
        send_bit(1'b0); send_ones(2);
        peek(3'd0, rv); check("R7 saturate keeps zero", rv, 8'hDF);

        // R10: gap-cycle toggles ignored, read clears ready
        do_reset();
        wr(3'd4, 8'h00);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            bit_in = i[0];
            @(negedge clk);
        end
        peek(3'd3, rv); check("R10 invalid bits ignored", rv, 8'h00);
        send_raw(8'h96);
        peek(3'd0, rv); check("R10 R4 byte after gap", rv, 8'h96);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule